// File: doc/BRIEF.md
# Dual-Channel Soft-Ramped Gain and Mute Controller

This block keeps a 16-bit control word that sets a mute request and a 7-bit target gain code for a left and a right channel. It drives out the gain code actually applied to each channel. That code never jumps to a new value. On every step tick it moves one code toward the target. This is how clicks and pops are avoided when the volume changes and when a channel is muted or unmuted.

Muting a channel first lowers its applied code, one step per tick, to the floor code 07h (-40 dB). The channel becomes fully muted only on the tick after that. While the channel is muted, its stored target is kept. Unmuting first releases the mute at the floor, then climbs back to the stored target. One code is 0.5 dB: 57h is 0 dB and 7Fh is +20 dB. Software can write the control word at any time, including in the middle of a ramp. The ramp then carries on from the present applied code.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: After reset, both channels hold a stored mute request with target 57h, both applied codes read 07h, and both muted flags read 1.
- R2: In the control word, bit 15 is the left mute request, bits 14:8 are the left target code, bit 7 is the right mute request and bits 6:0 are the right target code. A write takes effect in the cycle after wr_en_i is high.
- R3: Applied codes and muted flags change only in the cycle after step_i is high. A write alone leaves them unchanged. On a step, an unmuted channel moves its applied code by exactly one toward the target and holds once it reaches the target.
- R4: With a mute request pending, each step lowers the applied code by one until it reaches 07h. The next step sets the muted flag. The muted flag is never 1 while the applied code differs from 07h.
- R5: When the mute request is removed from a muted channel, the first step clears the muted flag with the applied code at 07h. Later steps raise the code one at a time up to the target that was stored while muted.
- R6: A target code from 00h to 06h acts as a mute request, even when the mute bit is 0.
- R7: A new target written during a ramp takes effect from the present applied code, with no jump. This includes unmuting while a mute ramp is still in progress.
- R8: The two channels ramp independently. A write or ramp on one channel does not change the other channel's applied code or muted flag beyond its own programmed behaviour.
- R9: The applied code never goes below 07h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word write data |
| step_i | input | 1 | Ramp step tick, one cycle wide |
| gain_l_o | output | 7 | Applied left gain code |
| gain_r_o | output | 7 | Applied right gain code |
| muted_l_o | output | 1 | Left channel fully muted |
| muted_r_o | output | 1 | Right channel fully muted |

## Verification
The assertions assume that step_i is a plain synchronous pulse and that every change of the applied code or state is caused by it. The bench therefore raises step_i for exactly one cycle per tick. It only writes the control word between ticks, and it waits for each write to register before the next tick. The stimulus sweeps every legal target code from an unmuted start and through a full mute ramp. It also covers every sub-floor code used as a mute request, as well as retargets in the middle of a ramp in both directions. The expected codes come from an arithmetic step model of the requirements.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
  localparam int NUM_CH = 2;  // index 0 = right (low field), 1 = left

  typedef enum logic [1:0] {
    ST_ACTIVE    = 2'd0,
    ST_RAMP_DOWN = 2'd1,
    ST_MUTED     = 2'd2,
    ST_RAMP_UP   = 2'd3
  } ch_state_e;
endpackage

// File: rtl/gain_ramp_regs.sv
module gain_ramp_regs
  import gain_ramp_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int RST_CODE = 'h57,
  localparam int FIELD_W = CODE_W + 1,
  localparam int WORD_W  = NUM_CH * FIELD_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [WORD_W-1:0]              wr_data_i,
  output logic [NUM_CH-1:0]              mute_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]  target_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        word_q[ch*FIELD_W +: FIELD_W] <= {1'b1, CODE_W'(RST_CODE)};
    end else if (wr_en_i) begin
      word_q <= wr_data_i;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_field
    assign mute_o[ch]   = word_q[ch*FIELD_W + CODE_W];
    assign target_o[ch] = word_q[ch*FIELD_W +: CODE_W];
  end

  // R2: a write lands in the register on the next edge
  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> word_q == $past(wr_data_i));
  assert_hold_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(word_q));
endmodule

// File: rtl/gain_ramp_chan.sv
module gain_ramp_chan
  import gain_ramp_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int MIN_CODE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              mute_i,
  input  logic [CODE_W-1:0] target_i,
  output logic [CODE_W-1:0] gain_o,
  output logic              muted_o
);
  localparam logic [CODE_W-1:0] MIN_C = CODE_W'(MIN_CODE);
  localparam logic [CODE_W-1:0] ONE_C = CODE_W'(1);

  ch_state_e         state_q, state_d;
  logic [CODE_W-1:0] gain_q, gain_d;
  logic              mute_req;

  // sub-floor target codes count as a mute request
  assign mute_req = mute_i || (target_i < MIN_C);

  always_comb begin
    state_d = state_q;
    gain_d  = gain_q;
    if (step_i) begin
      if (mute_req) begin
        if (state_q != ST_MUTED) begin
          if (gain_q <= MIN_C) begin
            state_d = ST_MUTED;
          end else begin
            gain_d  = gain_q - ONE_C;
            state_d = ST_RAMP_DOWN;
          end
        end
      end else if (state_q == ST_MUTED) begin
        // leave mute at the floor, climb on later ticks
        state_d = (target_i == MIN_C) ? ST_ACTIVE : ST_RAMP_UP;
      end else if (gain_q < target_i) begin
        gain_d  = gain_q + ONE_C;
        state_d = (gain_q + ONE_C == target_i) ? ST_ACTIVE : ST_RAMP_UP;
      end else if (gain_q > target_i) begin
        gain_d  = gain_q - ONE_C;
        state_d = (gain_q - ONE_C == target_i) ? ST_ACTIVE : ST_RAMP_DOWN;
      end else begin
        state_d = ST_ACTIVE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MUTED;
      gain_q  <= MIN_C;
    end else begin
      state_q <= state_d;
      gain_q  <= gain_d;
    end
  end

  assign gain_o  = gain_q;
  assign muted_o = (state_q == ST_MUTED);

  assert_hold_no_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(gain_q) && $stable(state_q));
  assert_one_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (gain_q == $past(gain_q)) || (gain_q == $past(gain_q) + ONE_C)
               || (gain_q == $past(gain_q) - ONE_C));
  assert_muted_at_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    muted_o |-> gain_q == MIN_C);
  assert_mute_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(muted_o) |-> $past(gain_q) == MIN_C && $past(step_i) && $past(mute_req));
  assert_unmute_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(muted_o) |-> gain_q == MIN_C && $past(!mute_req));
  assert_floor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_q >= MIN_C);
endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
  import gain_ramp_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int MIN_CODE = 7,
  parameter int RST_CODE = 'h57,
  localparam int WORD_W  = NUM_CH * (CODE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              step_i,
  output logic [CODE_W-1:0] gain_l_o,
  output logic [CODE_W-1:0] gain_r_o,
  output logic              muted_l_o,
  output logic              muted_r_o
);
  logic [NUM_CH-1:0]             mute_w;
  logic [NUM_CH-1:0][CODE_W-1:0] target_w;
  logic [NUM_CH-1:0][CODE_W-1:0] gain_w;
  logic [NUM_CH-1:0]             muted_w;

  gain_ramp_regs #(
    .CODE_W   (CODE_W),
    .RST_CODE (RST_CODE)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .mute_o    (mute_w),
    .target_o  (target_w)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    gain_ramp_chan #(
      .CODE_W   (CODE_W),
      .MIN_CODE (MIN_CODE)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step_i),
      .mute_i   (mute_w[ch]),
      .target_i (target_w[ch]),
      .gain_o   (gain_w[ch]),
      .muted_o  (muted_w[ch])
    );
  end

  assign gain_r_o  = gain_w[0];
  assign gain_l_o  = gain_w[1];
  assign muted_r_o = muted_w[0];
  assign muted_l_o = muted_w[1];
endmodule

// File: tb/gain_ramp_ctrl_bench.sv
module gain_ramp_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        step_i = 1'b0;
  logic [6:0]  gain_l_o, gain_r_o;
  logic        muted_l_o, muted_r_o;

  int errors = 0;
  int checks = 0;

  // model: index 0 = right, 1 = left
  logic       m_mute  [2];
  int         m_tgt   [2];
  int         m_gain  [2];
  logic       m_muted [2];

  always #2 clk_i = ~clk_i;

  gain_ramp_ctrl u_gain_ramp_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .step_i    (step_i),
    .gain_l_o  (gain_l_o),
    .gain_r_o  (gain_r_o),
    .muted_l_o (muted_l_o),
    .muted_r_o (muted_r_o)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, int'(gain_r_o),  m_gain[0],       "gain_r");
    check(tag, int'(gain_l_o),  m_gain[1],       "gain_l");
    check(tag, int'(muted_r_o), int'(m_muted[0]), "muted_r");
    check(tag, int'(muted_l_o), int'(m_muted[1]), "muted_l");
  endtask

  function automatic logic req(input int ch);
    return m_mute[ch] || (m_tgt[ch] < 7);
  endfunction

  function automatic logic settled(input int ch);
    if (req(ch)) return m_muted[ch];
    return !m_muted[ch] && (m_gain[ch] == m_tgt[ch]);
  endfunction

  task automatic write(input logic lm, input int lg, input logic rm, input int rg);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = {lm, 7'(lg), rm, 7'(rg)};
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_mute[1] = lm; m_tgt[1] = lg;
    m_mute[0] = rm; m_tgt[0] = rg;
    check_all("R3_write_no_jump");
  endtask

  task automatic tick(input string tag);
    @(negedge clk_i);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
    for (int ch = 0; ch < 2; ch++) begin
      if (req(ch)) begin
        if (!m_muted[ch]) begin
          if (m_gain[ch] == 7) m_muted[ch] = 1'b1;
          else m_gain[ch] = m_gain[ch] - 1;
        end
      end else if (m_muted[ch]) begin
        m_muted[ch] = 1'b0;
      end else if (m_gain[ch] < m_tgt[ch]) begin
        m_gain[ch] = m_gain[ch] + 1;
      end else if (m_gain[ch] > m_tgt[ch]) begin
        m_gain[ch] = m_gain[ch] - 1;
      end
    end
    check_all(tag);
  endtask

  task automatic settle(input string tag);
    int n = 0;
    while (!(settled(0) && settled(1)) && n < 300) begin
      tick(tag);
      n++;
    end
    check(tag, int'(settled(0) && settled(1)), 1, "settled");
  endtask

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      m_mute[ch] = 1'b1; m_tgt[ch] = 'h57; m_gain[ch] = 7; m_muted[ch] = 1'b1;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1_reset");

    // R3: idle cycles without a tick leave everything alone
    repeat (5) @(negedge clk_i);
    check_all("R3_idle_hold");

    // R1: the reset target is 57h; unmute only and ramp to it
    write(1'b0, 'h57, 1'b0, 'h57);
    tick("R5_first_tick_floor");
    check("R5", int'(gain_l_o), 7, "gain_l at unmute");
    settle("R1_reset_target");
    check("R1", int'(gain_l_o), 'h57, "gain_l reset target");
    write(1'b1, 'h57, 1'b1, 'h57);
    settle("R4_mute_ramp");

    // sweep every legal target: unmute ramp then mute ramp, channels mirrored (R8)
    for (int t = 7; t <= 127; t++) begin
      write(1'b0, t, 1'b0, 134 - t);
      settle("R5_R8_unmute_sweep");
      write(1'b1, t, 1'b1, 134 - t);
      settle("R4_R8_mute_sweep");
    end

    // R6: sub-floor codes mute the left channel, right untouched
    for (int c = 0; c < 7; c++) begin
      write(1'b0, 'h20, 1'b0, 'h57);
      settle("R6_setup");
      write(1'b0, c, 1'b0, 'h57);
      settle("R6_subfloor_mute");
      check("R6", int'(muted_l_o), 1, "muted_l for subfloor code");
      check("R8", int'(gain_r_o), 'h57, "gain_r independent");
    end

    // R7: retarget mid ramp, both directions
    write(1'b0, 'h60, 1'b0, 'h57);
    repeat (12) tick("R7_ramp_up");
    write(1'b0, 'h10, 1'b0, 'h57);
    settle("R7_retarget_down");
    write(1'b0, 'h70, 1'b0, 'h57);
    settle("R7_setup");
    write(1'b1, 'h70, 1'b0, 'h57);
    repeat (20) tick("R7_mute_partial");
    check("R7", int'(muted_l_o), 0, "muted_l mid ramp");
    write(1'b0, 'h70, 1'b0, 'h57);
    tick("R7_unmute_mid_down");
    check("R7", int'(gain_l_o), 'h70 - 20 + 1, "gain_l resumes upward");
    settle("R7_return");

    // R2: field positions, left mute bit only, right target 30h
    write(1'b1, 'h57, 1'b0, 'h30);
    settle("R2_fields");
    check("R2", int'(muted_l_o), 1, "left mute at bit 15");
    check("R2", int'(gain_r_o), 'h30, "right target at bits 6:0");
    write(1'b0, 'h7F, 1'b1, 'h30);
    settle("R2_fields_swap");
    check("R2", int'(gain_l_o), 'h7F, "left target at bits 14:8");
    check("R2", int'(muted_r_o), 1, "right mute at bit 7");

    // R9: full mute from max never dips under floor
    write(1'b1, 'h7F, 1'b1, 'h30);
    settle("R9_floor");
    check("R9", int'(gain_l_o), 7, "floor code");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule